// File: doc/BRIEF.md
# Multi-Bank GPIO Port Register File

This block holds the software-visible state of eight general-purpose I/O ports behind a simple register bus. Each port (bank) owns three 32-bit registers: a configuration word that picks, pin by pin, whether the pin senses, drives or is handed to another function; a data word; and a pull-up word. The banks sit at a 16-byte stride. Within a bank the configuration word is at offset 0x0, the data word at 0x4 and the pull-up word at 0x8.

The banks differ in width: 23, 11, 16, 16, 16, 8, 16 and 11 implemented pins for banks 0 to 7. Bank 0 uses one configuration bit per pin. A clear bit makes the pin an output. Banks 1 to 7 use a 2-bit field per pin. On those banks, every pin set as input has its external level passed through a two-flop synchroniser and copied into the data word. The output level presented to a pin changes only when a data write flips that pin's bit while the pin is set to drive.

Reads are combinational from the addressed register. Writes take effect at the clock edge on which `bus_we` is high.

Top module: `gpio_bank_regfile`

## Requirements
- R1: The bank index is `bus_addr[6:4]` when `bus_addr[7]` is 0. The low nibble selects configuration (0x0), data (0x4) or pull-up (0x8). Any other low nibble, and any address with `bus_addr[7]` set, reads as 0, and a write there changes no register.
- R2: After reset, bank 0's configuration reads 0x07FFFFFF. Every other configuration word, and every data word, reads 0.
- R3: After reset, the pull-up word reads 0x0000F000 in bank 3, 0x0000F800 in bank 6 and 0 elsewhere. A pull-up write stores all 32 bits, and the pull-up words change only on a pull-up write.
- R4: Bank b implements n(b) pins, with n = 23, 11, 16, 16, 16, 8, 16, 11 for b = 0..7. Data bits at position n(b) and above always read 0, including after a write of all ones.
- R5: In banks 1 to 7, pin p is governed by configuration bits [2p+1:2p]. Code 00 is input, 01 is output, and 10 or 11 is neither. `pin_oe` is 1 exactly for the implemented pins with code 01. A configuration write stores all 32 bits.
- R6: In bank 0, configuration bit p = 0 makes implemented pin p an output (`pin_oe` = 1). Bank 0 pins never copy `pin_in` into the data word.
- R7: In banks 1 to 7, the data bit of an implemented input pin takes the level of `pin_in` three clock edges after the pin changes (two synchroniser stages plus the data register). On a data write, such bits still take the sampled level rather than the written value.
- R8: A data write sets `pin_out` bit p to the written value only when pin p is implemented, is configured as output, and its written bit differs from the stored data bit. All other `pin_out` bits keep their value.
- R9: `pin_out` changes only on a data write. Configuration writes, pull-up writes and input changes leave it unchanged. `pin_out` and `pin_oe` are 0 for unimplemented pins, and `pin_out` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data from the register addressed by bus_addr |
| pin_in | input | 256 | External pin levels; bank b uses bits [32b+31:32b] |
| pin_out | output | 256 | Output level per pin, same layout |
| pin_oe | output | 256 | Output enable per pin, same layout |

## Verification
The assertions assume that `pin_in` may change at any cycle but reaches the data word only through the synchroniser. They also assume that a configuration or data write is a single-cycle `bus_we` pulse with a stable address. The tracking property for input pins compares each data bit with the synchronised level of the previous cycle, so it does not depend on how fast pins toggle. To keep its own expected values exact, the bench holds every pin change for at least three edges before the next bus access. It changes pins and the bus only on falling clock edges, and it never issues back-to-back writes without a gap.

// File: rtl/gpio_rf_pkg.sv
package gpio_rf_pkg;

  localparam int NUM_BANKS = 8;
  localparam int REG_W     = 32;
  localparam int ADDR_W    = 8;
  localparam int OFS_W     = 4;
  localparam int BANK_W    = $clog2(NUM_BANKS);
  localparam int FIELD_W   = 2;
  localparam int FIELDS    = REG_W / FIELD_W;

  localparam logic [OFS_W-1:0]   OFS_CFG  = 4'h0;
  localparam logic [OFS_W-1:0]   OFS_DAT  = 4'h4;
  localparam logic [OFS_W-1:0]   OFS_PULL = 4'h8;
  localparam logic [FIELD_W-1:0] FLD_IN   = 2'b00;
  localparam logic [FIELD_W-1:0] FLD_OUT  = 2'b01;

  typedef logic [REG_W-1:0] word_t;

  typedef enum logic [1:0] {SEL_CFG, SEL_DAT, SEL_PULL, SEL_NONE} reg_sel_e;

  typedef struct packed {
    logic              hit;
    logic [BANK_W-1:0] bank;
    reg_sel_e          sel;
  } bus_dec_t;

  // implemented pins per bank
  function automatic int pin_count(input int b);
    case (b)
      0:       return 23;
      1:       return 11;
      2, 3, 4: return 16;
      5:       return 8;
      6:       return 16;
      7:       return 11;
      default: return 0;
    endcase
  endfunction

  function automatic word_t pin_mask(input int b);
    word_t m;
    m = '0;
    for (int i = 0; i < REG_W; i++)
      if (i < pin_count(b)) m[i] = 1'b1;
    return m;
  endfunction

  function automatic word_t cfg_reset(input int b);
    return (b == 0) ? 32'h07ff_ffff : '0;
  endfunction

  function automatic word_t pull_reset(input int b);
    case (b)
      3:       return 32'h0000_f000;
      6:       return 32'h0000_f800;
      default: return '0;
    endcase
  endfunction

  // pins that drive from the data register
  function automatic word_t drive_bits(input int b, input word_t cfg);
    word_t v;
    v = '0;
    for (int i = 0; i < REG_W; i++) begin
      if (b == 0)
        v[i] = ~cfg[i];
      else if (i < FIELDS)
        v[i] = (cfg[FIELD_W*i +: FIELD_W] == FLD_OUT);
    end
    return v & pin_mask(b);
  endfunction

  // pins whose external level is copied into the data register
  function automatic word_t sense_bits(input int b, input word_t cfg);
    word_t v;
    v = '0;
    if (b != 0)
      for (int i = 0; i < FIELDS; i++)
        v[i] = (cfg[FIELD_W*i +: FIELD_W] == FLD_IN);
    return v & pin_mask(b);
  endfunction

  function automatic word_t merge_inputs(input word_t cur, input word_t lvl, input word_t sense);
    return (cur & ~sense) | (lvl & sense);
  endfunction

  function automatic bus_dec_t decode_addr(input logic [ADDR_W-1:0] a);
    bus_dec_t d;
    d.bank = a[OFS_W +: BANK_W];
    case (a[OFS_W-1:0])
      OFS_CFG:  d.sel = SEL_CFG;
      OFS_DAT:  d.sel = SEL_DAT;
      OFS_PULL: d.sel = SEL_PULL;
      default:  d.sel = SEL_NONE;
    endcase
    d.hit = (int'(a[ADDR_W-1:OFS_W]) < NUM_BANKS) && (d.sel != SEL_NONE);
    return d;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= din;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpio_rf_pkg::*;
#(
  parameter int BANK_IDX = 0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_cfg,
  input  logic  wr_dat,
  input  logic  wr_pull,
  input  word_t wdata,
  input  word_t lvl,
  output word_t cfg_q,
  output word_t dat_q,
  output word_t pull_q,
  output word_t pin_out,
  output word_t pin_oe,
  output word_t drive_upd,
  output word_t sense_mask
);

  localparam word_t MASK     = pin_mask(BANK_IDX);
  localparam word_t CFG_RST  = cfg_reset(BANK_IDX);
  localparam word_t PULL_RST = pull_reset(BANK_IDX);

  word_t drive_mask;
  word_t dat_base;
  word_t dat_d;

  assign drive_mask = drive_bits(BANK_IDX, cfg_q);
  assign sense_mask = sense_bits(BANK_IDX, cfg_q);
  assign pin_oe     = drive_mask;

  // pins that present a new level after this write
  assign drive_upd = wr_dat ? ((dat_q ^ wdata) & MASK & drive_mask) : '0;

  assign dat_base = wr_dat ? (wdata & MASK) : dat_q;
  assign dat_d    = merge_inputs(dat_base, lvl, sense_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= CFG_RST;
      dat_q   <= '0;
      pull_q  <= PULL_RST;
      pin_out <= '0;
    end else begin
      if (wr_cfg)  cfg_q  <= wdata;
      if (wr_pull) pull_q <= wdata;
      dat_q   <= dat_d;
      pin_out <= (pin_out & ~drive_upd) | (wdata & drive_upd);
    end
  end

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_rf_pkg::*;
(
  input  bus_dec_t                          dec,
  input  logic [NUM_BANKS-1:0][REG_W-1:0]   cfg_all,
  input  logic [NUM_BANKS-1:0][REG_W-1:0]   dat_all,
  input  logic [NUM_BANKS-1:0][REG_W-1:0]   pull_all,
  output word_t                             rdata
);

  always_comb begin
    rdata = '0;
    if (dec.hit) begin
      case (dec.sel)
        SEL_CFG:  rdata = cfg_all[dec.bank];
        SEL_DAT:  rdata = dat_all[dec.bank];
        SEL_PULL: rdata = pull_all[dec.bank];
        default:  rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_bank_regfile.sv
module gpio_bank_regfile
  import gpio_rf_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_we,
  input  logic [REG_W-1:0]            bus_wdata,
  output logic [REG_W-1:0]            bus_rdata,
  input  logic [NUM_BANKS*REG_W-1:0]  pin_in,
  output logic [NUM_BANKS*REG_W-1:0]  pin_out,
  output logic [NUM_BANKS*REG_W-1:0]  pin_oe
);

  localparam int PIN_W = NUM_BANKS * REG_W;

  bus_dec_t                        dec;
  logic [PIN_W-1:0]                lvl_flat;
  logic [NUM_BANKS-1:0][REG_W-1:0] cfg_all;
  logic [NUM_BANKS-1:0][REG_W-1:0] dat_all;
  logic [NUM_BANKS-1:0][REG_W-1:0] pull_all;
  logic [NUM_BANKS-1:0][REG_W-1:0] lvl_all;
  logic [NUM_BANKS-1:0][REG_W-1:0] sense_all;
  logic [NUM_BANKS-1:0][REG_W-1:0] upd_all;

  assign dec = decode_addr(bus_addr);

  gpio_in_sync #(
    .WIDTH  (PIN_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pin_in),
    .dout  (lvl_flat)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic  sel_bank;
    word_t bank_out;
    word_t bank_oe;

    assign sel_bank   = bus_we && dec.hit && (int'(dec.bank) == b);
    assign lvl_all[b] = lvl_flat[b*REG_W +: REG_W];

    gpio_port_bank #(
      .BANK_IDX (b)
    ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_cfg     (sel_bank && (dec.sel == SEL_CFG)),
      .wr_dat     (sel_bank && (dec.sel == SEL_DAT)),
      .wr_pull    (sel_bank && (dec.sel == SEL_PULL)),
      .wdata      (bus_wdata),
      .lvl        (lvl_all[b]),
      .cfg_q      (cfg_all[b]),
      .dat_q      (dat_all[b]),
      .pull_q     (pull_all[b]),
      .pin_out    (bank_out),
      .pin_oe     (bank_oe),
      .drive_upd  (upd_all[b]),
      .sense_mask (sense_all[b])
    );

    assign pin_out[b*REG_W +: REG_W] = bank_out;
    assign pin_oe[b*REG_W +: REG_W]  = bank_oe;
  end

  gpio_read_mux u_rmux (
    .dec      (dec),
    .cfg_all  (cfg_all),
    .dat_all  (dat_all),
    .pull_all (pull_all),
    .rdata    (bus_rdata)
  );

endmodule

// File: rtl/gpio_bank_regfile_chk.sv
module gpio_bank_regfile_chk
  import gpio_rf_pkg::*;
(
  input logic                              clk,
  input logic                              rst_n,
  input logic                              bus_we,
  input logic [ADDR_W-1:0]                 bus_addr,
  input logic [NUM_BANKS-1:0][REG_W-1:0]   cfg_all,
  input logic [NUM_BANKS-1:0][REG_W-1:0]   dat_all,
  input logic [NUM_BANKS-1:0][REG_W-1:0]   pull_all,
  input logic [NUM_BANKS-1:0][REG_W-1:0]   lvl_all,
  input logic [NUM_BANKS-1:0][REG_W-1:0]   sense_all,
  input logic [NUM_BANKS*REG_W-1:0]        pin_out,
  input logic [NUM_BANKS*REG_W-1:0]        pin_oe
);

  bus_dec_t cd;
  logic     dat_wr;

  assign cd     = decode_addr(bus_addr);
  assign dat_wr = bus_we && cd.hit && (cd.sel == SEL_DAT);

  // R9: outputs move only on a data write
  a_r9_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_wr |=> $stable(pin_out));

  // R8: a pin that was not driving keeps its output level
  a_r8_only_drivers: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pin_out ^ $past(pin_out)) & ~$past(pin_oe)) == '0));

  // R3: pull-up words only change under a bus write
  a_r3_pull_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(pull_all));

  // R1: writes outside the map touch no register
  a_r1_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !cd.hit) |=> ($stable(cfg_all) && $stable(pull_all)));

  // R6: bank 0 data only moves on its own data write
  a_r6_bank0_no_sample: assert property (@(posedge clk) disable iff (!rst_n)
    !(dat_wr && (cd.bank == '0)) |=> $stable(dat_all[0]));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
    // R4: bits beyond the pin count stay zero
    a_r4_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_all[b] & ~pin_mask(b)) == '0);

    // R7: sensed pins follow the synchronised level one edge later
    a_r7_track: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((dat_all[b] ^ $past(lvl_all[b])) & $past(sense_all[b])) == '0));
  end

endmodule

bind gpio_bank_regfile gpio_bank_regfile_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .cfg_all   (cfg_all),
  .dat_all   (dat_all),
  .pull_all  (pull_all),
  .lvl_all   (lvl_all),
  .sense_all (sense_all),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe)
);

// File: tb/gpio_bank_regfile_test.sv
`timescale 1ns/1ps
module gpio_bank_regfile_test;

  localparam int NB = 8;
  localparam int W  = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [7:0]        bus_addr = '0;
  logic              bus_we = 1'b0;
  logic [W-1:0]      bus_wdata = '0;
  logic [W-1:0]      bus_rdata;
  logic [NB*W-1:0]   pin_in = '0;
  logic [NB*W-1:0]   pin_out;
  logic [NB*W-1:0]   pin_oe;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [W-1:0] cfg_m [NB];
  logic [W-1:0] dat_m [NB];
  logic [W-1:0] pull_m[NB];
  logic [W-1:0] out_m [NB];

  always #10 clk = ~clk;

  gpio_bank_regfile uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic int m_pins(int b);
    int tbl[NB] = '{23, 11, 16, 16, 16, 8, 16, 11};
    return tbl[b];
  endfunction

  function automatic logic [W-1:0] m_mask(int b);
    return (64'h1 << m_pins(b)) - 1;
  endfunction

  function automatic logic [W-1:0] m_drv(int b, logic [W-1:0] c);
    logic [W-1:0] r = '0;
    if (b == 0) return ~c & m_mask(0);
    for (int p = 0; p < m_pins(b); p++)
      r[p] = (((c >> (2*p)) & 3) == 1);
    return r;
  endfunction

  function automatic logic [W-1:0] m_sns(int b, logic [W-1:0] c);
    logic [W-1:0] r = '0;
    if (b == 0) return '0;
    for (int p = 0; p < m_pins(b); p++)
      r[p] = (((c >> (2*p)) & 3) == 0);
    return r;
  endfunction

  function automatic void fold();
    for (int b = 0; b < NB; b++) begin
      logic [W-1:0] s = m_sns(b, cfg_m[b]);
      dat_m[b] = (dat_m[b] & ~s) | (pin_in[b*W +: W] & s);
    end
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [W-1:0] v);
    int b;
    @(negedge clk);
    fold();
    b = int'(a[6:4]);
    if (!a[7]) begin
      case (a[3:0])
        4'h0: cfg_m[b] = v;
        4'h4: begin
          logic [W-1:0] u = (dat_m[b] ^ v) & m_mask(b) & m_drv(b, cfg_m[b]);
          out_m[b] = (out_m[b] & ~u) | (v & u);
          dat_m[b] = v & m_mask(b);
          fold();
        end
        4'h8: pull_m[b] = v;
        default: ;
      endcase
    end
    bus_addr = a; bus_wdata = v; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    fold();
  endtask

  task automatic rd(logic [7:0] a, output logic [W-1:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic set_pins(int b, logic [W-1:0] v);
    @(negedge clk);
    pin_in[b*W +: W] = v;
    repeat (3) @(negedge clk);
    fold();
  endtask

  task automatic check_bank(int b);
    logic [W-1:0] v;
    fold();
    rd(8'(b*16 + 0), v); chk("R5 config readback", v, cfg_m[b]);
    rd(8'(b*16 + 4), v); chk("R7 data readback", v, dat_m[b]);
    rd(8'(b*16 + 8), v); chk("R3 pull-up readback", v, pull_m[b]);
    chk("R8 pin_out", pin_out[b*W +: W], out_m[b]);
    chk(b == 0 ? "R6 pin_oe" : "R5 pin_oe", pin_oe[b*W +: W], m_drv(b, cfg_m[b]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    logic [W-1:0] old;
    void'($urandom(32'd2024));
    for (int b = 0; b < NB; b++) begin
      cfg_m[b] = (b == 0) ? 32'h07ff_ffff : '0;
      dat_m[b] = '0; out_m[b] = '0;
      pull_m[b] = (b == 3) ? 32'h0000_f000 : (b == 6) ? 32'h0000_f800 : '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 R3: reset state
    for (int b = 0; b < NB; b++) begin
      rd(8'(b*16), v);     chk("R2 reset config", v, cfg_m[b]);
      rd(8'(b*16 + 4), v); chk("R2 reset data", v, 32'h0);
      rd(8'(b*16 + 8), v); chk("R3 reset pull-up", v, pull_m[b]);
    end
    chk("R9 reset pin_out", pin_out[W-1:0], 32'h0);

    // R1: unmapped reads and writes
    rd(8'h0C, v); chk("R1 hole offset reads zero", v, 32'h0);
    rd(8'h80, v); chk("R1 high address reads zero", v, 32'h0);
    wr(8'h80, 32'hdead_beef);
    wr(8'h3C, 32'h1234_5678);
    check_bank(0);
    check_bank(3);

    // R4: write all ones to bank 5 driving outputs
    wr(8'h50, 32'h0000_5555);
    wr(8'h54, 32'hffff_ffff);
    rd(8'h54, v); chk("R4 bank5 data masked", v, 32'h0000_00ff);
    chk("R8 bank5 pin_out", pin_out[5*W +: W], 32'h0000_00ff);

    // R6: bank 0 all outputs, pins never sampled
    set_pins(0, 32'hffff_ffff);
    rd(8'h04, v); chk("R6 bank0 not sampled", v, 32'h0);
    wr(8'h00, 32'h0);
    chk("R6 bank0 pin_oe", pin_oe[W-1:0], 32'h007f_ffff);
    wr(8'h04, 32'hffff_ffff);
    rd(8'h04, v); chk("R4 bank0 data masked", v, 32'h007f_ffff);
    chk("R6 bank0 pin_out", pin_out[W-1:0], 32'h007f_ffff);

    // R7: synchroniser latency on bank 2 (input after reset)
    rd(8'h24, old);
    @(negedge clk); pin_in[2*W +: W] = 32'h0000_a5c3;
    @(negedge clk); @(negedge clk);
    bus_addr = 8'h24; #1 chk("R7 not yet visible at edge 2", bus_rdata, old);
    @(negedge clk);
    #1 chk("R7 visible at edge 3", bus_rdata, 32'h0000_a5c3);
    fold();

    // R7: sampled level wins over a data write
    set_pins(1, 32'h0000_05a5);
    wr(8'h14, 32'h0000_07ff);
    rd(8'h14, v); chk("R7 input overrides write", v, 32'h0000_05a5);

    // R5: codes 10 and 11 neither drive nor sample
    wr(8'h60, 32'hffff_aaaa);
    wr(8'h64, 32'h0000_1234);
    rd(8'h64, v); chk("R5 alt code holds data", v, 32'h0000_1234);
    chk("R5 alt code no oe", pin_oe[6*W +: W], 32'h0);

    // R8 R9: partial drive update, then config toggling leaves outputs
    wr(8'h40, 32'h5555_5555);
    wr(8'h44, 32'h0000_00ff);
    chk("R8 bank4 drive", pin_out[4*W +: W], 32'h0000_00ff);
    wr(8'h40, 32'h5555_0000);
    wr(8'h44, 32'h0000_ff00);
    chk("R8 bank4 only outputs move", pin_out[4*W +: W], 32'h0000_ffff);
    set_pins(4, 32'h0);
    wr(8'h40, 32'h0);
    wr(8'h40, 32'h5555_5555);
    wr(8'h48, 32'h0);
    chk("R9 config change keeps pin_out", pin_out[4*W +: W], 32'h0000_ffff);
    check_bank(4);

    // random mix
    for (int it = 0; it < 500; it++) begin
      int b = int'($urandom % NB);
      case ($urandom % 5)
        0: set_pins(b, $urandom);
        1: wr(8'(b*16), ($urandom % 2) ? $urandom : ($urandom & 32'h5555_5555));
        2, 3: wr(8'(b*16 + 4), $urandom);
        default: begin
          if ($urandom % 3 == 0) wr(8'(b*16 + 8), $urandom);
          check_bank(b);
        end
      endcase
    end
    for (int b = 0; b < NB; b++) check_bank(b);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule